// File: doc/BRIEF.md
# PHY Management Register File

This block models the management side of a single Ethernet PHY together with the MAC-side command registers that reach it. A host writes a small set of registers: the target PHY and register address, a transmit-data word, and a command word. It reads back a receive-data word and a link-fail status bit. The PHY side holds sixteen 16-bit registers. Their reset values are fixed, three of them are read-only, two carry link-dependent bits, and a soft-reset bit returns all of them to their reset values.

Only one management address, the PHY identifier parameter (default 1), is served. A read command aimed at any other address returns all ones, and a write aimed at it has no effect. The PHY can be written in two ways: by issuing the write command, which uses the held transmit data, or by writing the transmit-data register while the served address is selected, which writes the PHY register at once. Every host access completes in the cycle it is presented. Reads return combinationally, and register updates land on the next rising edge. The host interface is a plain register port with no handshake, because no access ever stalls.

Host offsets (host_addr): 0 command, 1 address, 2 transmit data, 3 receive data, 4 status. Other offsets read zero.

Top module: `mii_mgmt_regfile`

## Requirements
- R1: After reset, with link_up low, the PHY registers hold 0 = 0x1000, 1 = 0x7868, 2 = 0x2000, 3 = 0x5C90, 4 = 0x01E1, and 0 in every other register. All host registers read 0.
- R2: A PHY write to register 0 with bit 15 set returns all sixteen PHY registers to their R1 values instead of storing the word. The link bits of R4 are then applied for the current link_up.
- R3: PHY registers 1, 2 and 3 ignore writes. Registers 0 (bit 15 clear) and 4 to 15 store the full 16-bit word written.
- R4: One edge after link_up rises, bit 2 of register 1 is set and 0x01E1 is ORed into register 5. One edge after link_up falls, bit 2 of register 1 is cleared and register 5 is ANDed with 0x01FF.
- R5: The address register holds the PHY address in bits 4:0 and the register address in bits 12:8. Writing the command register with bit 1 set loads the receive-data register (offset 3, bits 15:0) with the addressed PHY register when the PHY address is 1, and with 0xFFFF otherwise.
- R6: Writing the command register with bit 2 set writes the held transmit data (offset 2, bits 15:0) into the addressed PHY register, only when the PHY address is 1.
- R7: Writing the transmit-data register stores the word and, when the PHY address is 1, writes it into the addressed PHY register in the same cycle.
- R8: A command write with bit 1 set loads the status bit (offset 4, bit 0) with the inverse of link_up.
- R9: While the stored command bit 0 (scan) is set, each change of link_up sets the status bit to the inverse of link_up one edge later. With scan clear, a link change leaves the status bit unchanged.
- R10: Host writes to the status and receive-data registers are ignored.
- R11: PHY register addresses 16 to 31 read as zero and ignore writes. They do not alias onto registers 0 to 15.
- R12: When a PHY write and a link change fall in the same cycle, the written value is stored with the R4 adjustment applied on top of it. A command with bits 2 and 1 both set returns the newly written value (or the reset value after a soft reset) in the receive-data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe, one access per cycle |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| link_up | input | 1 | Current link state from the line side |

## Verification
Two pairs of functions can fall in the same cycle. The first is a host PHY write and a link transition. The bench drops link_up on the same negative edge that it presents a transmit-data write to register 5, and expects the written word masked with 0x01FF. The second is a write and a read inside one command word. The bench issues a combined write-and-read command, once to an ordinary register and once as a soft reset, and expects the receive-data register to hold the post-write value in each case.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

  // Host register offsets
  localparam int HOFF_CMD  = 0;
  localparam int HOFF_ADDR = 1;
  localparam int HOFF_TXD  = 2;
  localparam int HOFF_RXD  = 3;
  localparam int HOFF_STAT = 4;

  // Command word bits
  localparam int CMD_SCAN = 0;
  localparam int CMD_RD   = 1;
  localparam int CMD_WR   = 2;
  localparam int CMD_W    = 3;

  // Address register field positions
  localparam int PHYF_LSB = 0;
  localparam int REGF_LSB = 8;

  // PHY side constants
  localparam int          SOFT_RST_BIT = 15;
  localparam int          LINK_REG     = 1;
  localparam int          LINK_BIT     = 2;
  localparam int          PARTNER_REG  = 5;
  localparam logic [15:0] PARTNER_SET  = 16'h01E1;
  localparam logic [15:0] PARTNER_KEEP = 16'h01FF;

  function automatic logic [15:0] phy_rst_val(input int idx);
    case (idx)
      0:       return 16'h1000;
      1:       return 16'h7868;
      2:       return 16'h2000;
      3:       return 16'h5C90;
      4:       return 16'h01E1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit phy_read_only(input int idx);
    return (idx >= 1) && (idx <= 3);
  endfunction

endpackage

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mii_mgmt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_next,
  output logic              link_chg
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic              link_q;
  logic              soft_rst;
  logic [DATA_W-1:0] nxt_arr [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  assign link_chg = link_up ^ link_q;
  assign soft_rst = wr_en && (wr_idx == '0) && wr_data[SOFT_RST_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [DATA_W-1:0] RST = DATA_W'(phy_rst_val(i));
    localparam bit                RO  = phy_read_only(i);

    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] nxt;
    logic              hit;

    assign hit = wr_en && !soft_rst && !RO && (wr_idx == IDX_W'(i));

    always_comb begin
      nxt = soft_rst ? RST : cur_q;
      if (hit) nxt = wr_data;
      if (soft_rst || link_chg) begin
        if (i == LINK_REG)    nxt[LINK_BIT] = link_up;
        if (i == PARTNER_REG) nxt = link_up ? (nxt | DATA_W'(PARTNER_SET))
                                            : (nxt & DATA_W'(PARTNER_KEEP));
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= RST;
      else        cur_q <= nxt;
    end

    assign nxt_arr[i] = nxt;
  end

  // Read returns the value the register holds after this cycle
  always_comb begin
    if (int'(rd_idx) < NUM_REGS) rd_next = nxt_arr[rd_idx[SEL_W-1:0]];
    else                         rd_next = '0;
  end

endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mii_mgmt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 5,
  parameter int PHY_ID  = 1,
  parameter int HOST_AW = 3,
  parameter int HOST_DW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  input  logic               link_up,
  input  logic               link_chg,
  input  logic [DATA_W-1:0]  phy_rd_next,
  output logic               phy_wr_en,
  output logic [IDX_W-1:0]   phy_wr_idx,
  output logic [DATA_W-1:0]  phy_wr_data,
  output logic [IDX_W-1:0]   phy_rd_idx,
  output logic [IDX_W-1:0]   phy_addr_q,
  output logic [IDX_W-1:0]   reg_idx_q,
  output logic [DATA_W-1:0]  tx_data_q,
  output logic [DATA_W-1:0]  rx_data_q,
  output logic [CMD_W-1:0]   cmd_q,
  output logic               link_fail_q
);

  logic we_cmd, we_addr, we_txd;
  logic phy_sel;
  logic rd_req;
  wire  unused_wdata_hi = ^host_wdata[HOST_DW-1:DATA_W];

  assign we_cmd  = host_we && (host_addr == HOST_AW'(HOFF_CMD));
  assign we_addr = host_we && (host_addr == HOST_AW'(HOFF_ADDR));
  assign we_txd  = host_we && (host_addr == HOST_AW'(HOFF_TXD));
  assign phy_sel = (phy_addr_q == IDX_W'(PHY_ID));
  assign rd_req  = we_cmd && host_wdata[CMD_RD];

  // PHY write path: command-driven or immediate on transmit-data write
  always_comb begin
    phy_wr_en   = 1'b0;
    phy_wr_data = tx_data_q;
    if (we_cmd && host_wdata[CMD_WR] && phy_sel) begin
      phy_wr_en = 1'b1;
    end else if (we_txd && phy_sel) begin
      phy_wr_en   = 1'b1;
      phy_wr_data = host_wdata[DATA_W-1:0];
    end
  end

  assign phy_wr_idx = reg_idx_q;
  assign phy_rd_idx = reg_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_addr_q <= '0;
      reg_idx_q  <= '0;
      tx_data_q  <= '0;
      cmd_q      <= '0;
    end else begin
      if (we_addr) begin
        phy_addr_q <= host_wdata[PHYF_LSB +: IDX_W];
        reg_idx_q  <= host_wdata[REGF_LSB +: IDX_W];
      end
      if (we_txd) tx_data_q <= host_wdata[DATA_W-1:0];
      if (we_cmd) cmd_q     <= host_wdata[CMD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data_q <= '0;
    end else if (rd_req) begin
      rx_data_q <= phy_sel ? phy_rd_next : '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_fail_q <= 1'b0;
    end else if (rd_req || (cmd_q[CMD_SCAN] && link_chg)) begin
      link_fail_q <= !link_up;
    end
  end

endmodule

// File: rtl/mii_mgmt_regfile.sv
module mii_mgmt_regfile
  import mii_mgmt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int PHY_ID   = 1,
  parameter int HOST_AW  = 3,
  parameter int HOST_DW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               link_up
);

  localparam int IDX_W = 5;

  logic              phy_wr_en;
  logic [IDX_W-1:0]  phy_wr_idx;
  logic [DATA_W-1:0] phy_wr_data;
  logic [IDX_W-1:0]  phy_rd_idx;
  logic [DATA_W-1:0] phy_rd_next;
  logic              link_chg;
  logic [IDX_W-1:0]  phy_addr_q;
  logic [IDX_W-1:0]  reg_idx_q;
  logic [DATA_W-1:0] tx_data_q;
  logic [DATA_W-1:0] rx_data_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              link_fail_q;

  mgmt_host_regs #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .PHY_ID (PHY_ID),
    .HOST_AW(HOST_AW),
    .HOST_DW(HOST_DW)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .link_up    (link_up),
    .link_chg   (link_chg),
    .phy_rd_next(phy_rd_next),
    .phy_wr_en  (phy_wr_en),
    .phy_wr_idx (phy_wr_idx),
    .phy_wr_data(phy_wr_data),
    .phy_rd_idx (phy_rd_idx),
    .phy_addr_q (phy_addr_q),
    .reg_idx_q  (reg_idx_q),
    .tx_data_q  (tx_data_q),
    .rx_data_q  (rx_data_q),
    .cmd_q      (cmd_q),
    .link_fail_q(link_fail_q)
  );

  mgmt_phy_regs #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .IDX_W   (IDX_W)
  ) u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .wr_en   (phy_wr_en),
    .wr_idx  (phy_wr_idx),
    .wr_data (phy_wr_data),
    .rd_idx  (phy_rd_idx),
    .rd_next (phy_rd_next),
    .link_chg(link_chg)
  );

  always_comb begin
    host_rdata = '0;
    case (int'(host_addr))
      HOFF_CMD:  host_rdata[CMD_W-1:0] = cmd_q;
      HOFF_ADDR: begin
        host_rdata[PHYF_LSB +: IDX_W] = phy_addr_q;
        host_rdata[REGF_LSB +: IDX_W] = reg_idx_q;
      end
      HOFF_TXD:  host_rdata[DATA_W-1:0] = tx_data_q;
      HOFF_RXD:  host_rdata[DATA_W-1:0] = rx_data_q;
      HOFF_STAT: host_rdata[0] = link_fail_q;
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mii_mgmt_regfile_chk.sv
module mii_mgmt_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_we,
  input logic [2:0]  host_addr,
  input logic        wd_rd,
  input logic        link_up,
  input logic [4:0]  phy_addr,
  input logic [15:0] rx_data,
  input logic        link_fail,
  input logic        scan_on
);

  logic rd_cmd;
  assign rd_cmd = host_we && (host_addr == 3'd0) && wd_rd;

  // R5: foreign PHY address reads back all ones
  assert_foreign_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && (phy_addr != 5'd1) |=> rx_data == 16'hFFFF);

  // R8: read command samples the link state
  assert_rd_linkfail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> link_fail == !$past(link_up));

  // R9: scan follows a link change
  assert_scan_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_on && (link_up != $past(link_up)) |=> link_fail == !$past(link_up));

  // R10: status only moves on a read command or a scanned link change
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd && !(scan_on && (link_up != $past(link_up))) |=> $stable(link_fail));

  // R10: receive data only moves on a read command
  assert_rxdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> $stable(rx_data));

endmodule

bind mii_mgmt_regfile mii_mgmt_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .host_we  (host_we),
  .host_addr(host_addr),
  .wd_rd    (host_wdata[1]),
  .link_up  (link_up),
  .phy_addr (phy_addr_q),
  .rx_data  (rx_data_q),
  .link_fail(link_fail_q),
  .scan_on  (cmd_q[0])
);

// File: tb/test_mii_mgmt_regfile.sv
`timescale 1ns/1ps
module test_mii_mgmt_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        link_up = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [31:0] d;

  always #2.5 clk = ~clk;

  mii_mgmt_regfile i_mii_mgmt_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .link_up   (link_up)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [31:0] v);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic set_addr(input int phy, input int rg);
    hw(3'd1, (32'(rg) << 8) | 32'(phy));
  endtask

  task automatic phy_rd(input int phy, input int rg, output logic [31:0] v);
    set_addr(phy, rg);
    hw(3'd0, 32'h2);
    hr(3'd3, v);
  endtask

  task automatic phy_wr(input int rg, input logic [15:0] v);
    set_addr(1, rg);
    hw(3'd2, {16'h0, v});
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 5; a++) begin
      hr(3'(a), d); chk("R1 host reg", d, 32'h0);
    end
    phy_rd(1, 0, d); chk("R1 reg0", d, 32'h1000);
    phy_rd(1, 1, d); chk("R1 reg1", d, 32'h7868);
    phy_rd(1, 2, d); chk("R1 reg2", d, 32'h2000);
    phy_rd(1, 3, d); chk("R1 reg3", d, 32'h5C90);
    phy_rd(1, 4, d); chk("R1 reg4", d, 32'h01E1);
    for (int r = 5; r < 16; r++) begin
      phy_rd(1, r, d); chk("R1 zero reg", d, 32'h0);
    end
  endtask

  task automatic t_link;
    set_link(1'b1);
    phy_rd(1, 1, d); chk("R4 up reg1", d, 32'h786C);
    phy_rd(1, 5, d); chk("R4 up reg5", d, 32'h01E1);
    phy_wr(5, 16'hFE5A);
    phy_rd(1, 5, d); chk("R3 reg5 store", d, 32'hFE5A);
    set_link(1'b0);
    phy_rd(1, 5, d); chk("R4 down reg5", d, 32'h005A);
    phy_rd(1, 1, d); chk("R4 down reg1", d, 32'h7868);
    set_link(1'b1);
    phy_rd(1, 5, d); chk("R4 reup reg5", d, 32'h01FB);
  endtask

  task automatic t_ro;
    phy_wr(1, 16'hFFFF); phy_wr(2, 16'h0); phy_wr(3, 16'h0);
    phy_rd(1, 1, d); chk("R3 reg1 ro", d, 32'h786C);
    phy_rd(1, 2, d); chk("R3 reg2 ro", d, 32'h2000);
    phy_rd(1, 3, d); chk("R3 reg3 ro", d, 32'h5C90);
    phy_wr(4, 16'hABCD); phy_wr(15, 16'h1234); phy_wr(0, 16'h3100);
    phy_rd(1, 4, d);  chk("R3 reg4", d, 32'hABCD);
    phy_rd(1, 15, d); chk("R3 reg15", d, 32'h1234);
    phy_rd(1, 0, d);  chk("R3 reg0", d, 32'h3100);
  endtask

  task automatic t_softrst;
    phy_wr(0, 16'h8000);
    phy_rd(1, 0, d);  chk("R2 reg0", d, 32'h1000);
    phy_rd(1, 4, d);  chk("R2 reg4", d, 32'h01E1);
    phy_rd(1, 15, d); chk("R2 reg15", d, 32'h0);
    phy_rd(1, 1, d);  chk("R2 reg1 link", d, 32'h786C);
    phy_rd(1, 5, d);  chk("R2 reg5 link", d, 32'h01E1);
  endtask

  task automatic t_other_phy;
    phy_rd(2, 4, d); chk("R5 foreign ones", d, 32'hFFFF);
    set_addr(2, 4);
    hw(3'd2, 32'h5555);
    hw(3'd0, 32'h4);
    phy_rd(1, 4, d); chk("R6 foreign write ignored", d, 32'h01E1);
  endtask

  task automatic t_cmd_write;
    set_addr(2, 6);
    hw(3'd2, 32'h1111);
    phy_rd(1, 6, d); chk("R6 no write before command", d, 32'h0);
    hw(3'd0, 32'h4);
    phy_rd(1, 6, d); chk("R6 command write", d, 32'h1111);
    phy_wr(7, 16'h7777);
    phy_rd(1, 7, d); chk("R7 immediate write", d, 32'h7777);
  endtask

  task automatic t_hi_regs;
    set_addr(1, 20);
    hw(3'd2, 32'hBEEF);
    hw(3'd0, 32'h4);
    phy_rd(1, 20, d); chk("R11 high reads zero", d, 32'h0);
    phy_rd(1, 4, d);  chk("R11 no alias", d, 32'h01E1);
  endtask

  task automatic t_linkfail;
    set_link(1'b0);
    hr(3'd4, d); chk("R9 scan off holds", d, 32'h0);
    hw(3'd0, 32'h2);
    hr(3'd4, d); chk("R8 read refresh down", d, 32'h1);
    set_link(1'b1);
    hr(3'd4, d); chk("R9 scan off holds up", d, 32'h1);
    hw(3'd0, 32'h2);
    hr(3'd4, d); chk("R8 read refresh up", d, 32'h0);
    hw(3'd0, 32'h1);
    set_link(1'b0);
    hr(3'd4, d); chk("R9 scan down", d, 32'h1);
    set_link(1'b1);
    hr(3'd4, d); chk("R9 scan up", d, 32'h0);
  endtask

  task automatic t_status_ro;
    phy_rd(1, 4, d);
    hw(3'd4, 32'h1);
    hr(3'd4, d); chk("R10 status ignores write", d, 32'h0);
    hw(3'd3, 32'h1234);
    hr(3'd3, d); chk("R10 rxdata ignores write", d, 32'h01E1);
  endtask

  task automatic t_same_cycle;
    set_addr(1, 5);
    @(negedge clk);
    link_up = 1'b0; host_we = 1'b1; host_addr = 3'd2; host_wdata = 32'hFFFF;
    @(negedge clk);
    host_we = 1'b0;
    phy_rd(1, 5, d); chk("R12 write with link drop", d, 32'h01FF);
    phy_rd(1, 1, d); chk("R12 link bit", d, 32'h7868);
    set_addr(2, 8);
    hw(3'd2, 32'h2468);
    set_addr(1, 8);
    hw(3'd0, 32'h6);
    hr(3'd3, d); chk("R12 write then read", d, 32'h2468);
    phy_wr(0, 16'h2100);
    set_addr(2, 0);
    hw(3'd2, 32'h8000);
    set_addr(1, 0);
    hw(3'd0, 32'h6);
    hr(3'd3, d); chk("R12 soft reset then read", d, 32'h1000);
    phy_rd(1, 5, d); chk("R2 reg5 after reset link down", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_link();
    t_ro();
    t_softrst();
    t_other_phy();
    t_cmd_write();
    t_hi_regs();
    t_linkfail();
    t_status_ro();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule